// File: doc/BRIEF.md
# Flash Command Write Sequencer

This block sits on the write side of a parallel NOR flash device. Every bus write strobe delivers an address and a data byte. The sequencer checks these writes against the unlock handshake and the command codes. When a sequence completes, it raises a single-cycle request toward the program/erase engine: return to array reads, auto-select, program one location, erase a set of blocks, erase the whole chip, suspend an erase, or resume one. A mode input selects byte-wide or word-wide addressing. In byte mode, bit 0 of the address port is the half-word select, and the word address sits in bits 19:1. In word mode, the word address sits in bits 18:0.

The sequencer also tells the read multiplexer which source to present: array data, identification codes, or engine status. For block erase, it gathers a list of target blocks in a 19-bit mask. Blocks keep arriving while a restartable quiet-period counter runs, and the erase request is issued only when that counter runs out.

Top module: `flash_cmd_seq`

## Requirements
- R1: The unlock handshake is two writes. The first is AAh and the second is 55h. In byte mode their addresses are AAAh then 555h; in word mode they are 555h then 2AAh. Only address port bits 11:0 are compared. A wrong address or wrong data in either write aborts the sequence.
- R2: After the unlock pair, writing 90h at the first-unlock address pulses `req_autosel`. From then on, `read_mode` reads 01 (signature) until a read-reset or an abort.
- R3: After the unlock pair, writing A0h at the first-unlock address arms programming. The next write pulses `req_program` for one cycle, with that write's address on `prog_addr` and its data on `prog_data`.
- R4: After the unlock pair, writing 80h and then a second unlock pair, a write of 10h at the first-unlock address pulses `req_chip_erase`.
- R5: In the same erase sequence, a 30h write adds the addressed block to `erase_mask` and starts the quiet-period counter. Each further 30h write, with no unlock needed, adds a block and restarts the count. `req_block_erase` pulses TMO_CYC+1 cycles after the last such write, with the mask valid in that cycle; the mask is zero one cycle later. The block layout (word addresses):
  - blocks 0–14 are 32K-word regions starting at 0;
  - block 15 starts at 78000h;
  - block 16 starts at 7C000h;
  - block 17 starts at 7D000h;
  - block 18 starts at 7E000h.
  Mask bit n stands for block n.
- R6: A write that does not fit the sequence in progress returns the sequencer to idle. This includes a non-30h write while blocks are being collected and a wrong unlock before the erase confirm. After an abort no request is issued, `read_mode` is 00 (array), and any pending block list is dropped.
- R7: F0h, alone or after the unlock pair, pulses `req_read_reset` and selects array reads. It is ignored while an erase is running or suspended.
- R8: While either engine busy input is high, every write is ignored except B0h during an erase, which pulses `req_suspend`. While suspended and idle, a 30h write pulses `req_resume`. At most one request is high in any cycle.
- R9: `read_mode` is 10 (status) while the engine reports busy or while blocks are being collected.
- R10: A synchronous reset clears any partial sequence, the suspend state, the block mask and all requests, and selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up / low supply) |
| word_mode | input | 1 | 1 = word-wide addressing, 0 = byte-wide |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 20 | Write address as seen on the bus |
| wr_data | input | 8 | Write data / command code |
| eng_prog_busy | input | 1 | Engine is programming |
| eng_erase_busy | input | 1 | Engine is erasing |
| req_read_reset | output | 1 | Pulse: return to array read |
| req_autosel | output | 1 | Pulse: auto-select entered |
| req_program | output | 1 | Pulse: program one location |
| req_block_erase | output | 1 | Pulse: erase blocks in `erase_mask` |
| req_chip_erase | output | 1 | Pulse: erase all blocks |
| req_suspend | output | 1 | Pulse: suspend running erase |
| req_resume | output | 1 | Pulse: resume suspended erase |
| prog_addr | output | 20 | Address captured for programming |
| prog_data | output | 8 | Data captured for programming |
| erase_mask | output | 19 | Collected block list |
| read_mode | output | 2 | 00 array, 01 signature, 10 status |

## Verification
The hardest state to reach is the multi-block collection window with a restart in the middle. The bench sends an erase confirm, waits a few cycles, then sends two more confirms: one in byte mode and one in word mode. It then counts the exact cycle in which the erase request must appear and checks the mask in that cycle and the cycle after. It also reaches the suspended state by holding the erase-busy input high, sending the suspend code, and then checking that a read-reset is ignored before the resume.

// File: rtl/flash_seq_pkg.sv
// Shared definitions for the flash command sequencer.
// Assumes a 19-bit word address space with a top-located boot region.
package flash_seq_pkg;

    localparam int NUM_BLOCKS = 19;
    localparam int WADDR_W    = 19;

    typedef enum logic [2:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS3, S_ERS4, S_ERS5, S_ETMR
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'b00,
        RM_SIG    = 2'b01,
        RM_STATUS = 2'b10
    } rd_mode_t;

    localparam logic [7:0] CD_KEY_A   = 8'hAA;
    localparam logic [7:0] CD_KEY_B   = 8'h55;
    localparam logic [7:0] CD_ASEL    = 8'h90;
    localparam logic [7:0] CD_PROG    = 8'hA0;
    localparam logic [7:0] CD_ERSETUP = 8'h80;
    localparam logic [7:0] CD_BLKCONF = 8'h30;
    localparam logic [7:0] CD_CHIP    = 8'h10;
    localparam logic [7:0] CD_RESET   = 8'hF0;
    localparam logic [7:0] CD_SUSP    = 8'hB0;
    localparam logic [7:0] CD_RESUME  = 8'h30;

    // Lowest word address of block idx; idx == NUM_BLOCKS gives the end of the space.
    function automatic logic [19:0] blk_base(input int idx);
        if (idx < 15) return 20'(idx * 32768);
        case (idx)
            15:      return 20'h78000;
            16:      return 20'h7C000;
            17:      return 20'h7D000;
            18:      return 20'h7E000;
            default: return 20'h80000;
        endcase
    endfunction

endpackage

// File: rtl/fcs_unlock_match.sv
// Compares a write address against the two unlock addresses.
// Assumes only address port bits 11:0 are significant for unlock/setup writes.
module fcs_unlock_match (
    input  logic [11:0] addr_lo,
    input  logic        word_mode,
    output logic        hit_first,
    output logic        hit_second
);
    // Pick the expected pair for the current width mode.
    always_comb begin
        if (word_mode) begin
            hit_first  = (addr_lo == 12'h555);
            hit_second = (addr_lo == 12'h2AA);
        end else begin
            hit_first  = (addr_lo == 12'hAAA);
            hit_second = (addr_lo == 12'h555);
        end
    end
endmodule

// File: rtl/fcs_block_map.sv
// Decodes a bus address into a one-hot block select.
// Assumes byte mode carries the half-word select on bit 0 of the port.
module fcs_block_map
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  word_mode,
    output logic [NUM_BLOCKS-1:0] blk_sel
);
    logic [19:0] waddr;

    // Normalise to a word address, zero-extended by one bit.
    always_comb waddr = word_mode ? {1'b0, addr[WADDR_W-1:0]} : {1'b0, addr[WADDR_W:1]};

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        localparam logic [19:0] LO = blk_base(i);
        localparam logic [19:0] HI = blk_base(i + 1);
        assign blk_sel[i] = (waddr >= LO) && (waddr < HI);
    end
endmodule

// File: rtl/fcs_erase_timer.sv
// Restartable quiet-period counter for block collection.
// Assumes TMO_CYC >= 2; expire is high for one cycle when the count runs out.
module fcs_erase_timer #(
    parameter int TMO_CYC = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cancel,
    output logic running,
    output logic expire
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Count down from LOAD after each restart; stop on cancel or at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (cancel) begin
            running <= 1'b0;
        end else if (restart) begin
            running <= 1'b1;
            cnt     <= LOAD;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign expire = running && (cnt == '0) && !restart && !cancel;

    AST_TMR_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !cancel) |=> (running && !expire)); // R5
endmodule

// File: rtl/flash_cmd_seq.sv
// Command-write sequencer for a parallel NOR flash.
// Decodes unlock/command writes into one-cycle engine requests, collects
// the block erase list and reports the read source. Assumes the engine
// raises eng_erase_busy only while an erase is actually running.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int TMO_CYC = 2048
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_mode,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  eng_prog_busy,
    input  logic                  eng_erase_busy,
    output logic                  req_read_reset,
    output logic                  req_autosel,
    output logic                  req_program,
    output logic                  req_block_erase,
    output logic                  req_chip_erase,
    output logic                  req_suspend,
    output logic                  req_resume,
    output logic [ADDR_W-1:0]     prog_addr,
    output logic [7:0]            prog_data,
    output logic [NUM_BLOCKS-1:0] erase_mask,
    output logic [1:0]            read_mode
);
    seq_state_t state, nxt;
    logic asel, susp;
    logic hit1, hit2;
    logic [NUM_BLOCKS-1:0] blk_sel;
    logic tmr_run, tmr_exp, tmr_restart, tmr_cancel;
    logic eng_busy;
    logic d_rreset, d_asel, d_prog, d_berase, d_cerase, d_susp, d_resume;
    logic asel_set, asel_clr, add_blk;

    fcs_unlock_match u_unlock (
        .addr_lo   (wr_addr[11:0]),
        .word_mode (word_mode),
        .hit_first (hit1),
        .hit_second(hit2)
    );

    fcs_block_map #(.ADDR_W(ADDR_W)) u_bmap (
        .addr     (wr_addr),
        .word_mode(word_mode),
        .blk_sel  (blk_sel)
    );

    fcs_erase_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(tmr_restart),
        .cancel (tmr_cancel),
        .running(tmr_run),
        .expire (tmr_exp)
    );

    assign eng_busy = eng_prog_busy | eng_erase_busy;

    // Next-state and request decode for one bus write.
    always_comb begin
        nxt = state;
        {d_rreset, d_asel, d_prog, d_berase, d_cerase, d_susp, d_resume} = '0;
        asel_set = 1'b0; asel_clr = 1'b0; add_blk = 1'b0;
        tmr_restart = 1'b0; tmr_cancel = 1'b0;
        if (wr_en && eng_busy) begin
            d_susp = eng_erase_busy && (wr_data == CD_SUSP);
        end else if (wr_en) begin
            // Default outcome of any unexpected write is an abort.
            nxt = S_IDLE; asel_clr = 1'b1; tmr_cancel = 1'b1;
            unique case (state)
                S_IDLE: begin
                    if (wr_data == CD_KEY_A && hit1) begin
                        nxt = S_UNL1; asel_clr = 1'b0;
                    end else if (wr_data == CD_RESET) begin
                        d_rreset = !susp;
                    end else if (wr_data == CD_RESUME && susp) begin
                        d_resume = 1'b1;
                    end
                end
                S_UNL1: if (wr_data == CD_KEY_B && hit2) begin
                    nxt = S_UNL2; asel_clr = 1'b0;
                end
                S_UNL2: begin
                    if (wr_data == CD_RESET) begin
                        d_rreset = !susp;
                    end else if (hit1 && wr_data == CD_ASEL) begin
                        d_asel = 1'b1; asel_set = 1'b1;
                    end else if (hit1 && wr_data == CD_PROG) begin
                        nxt = S_PROG;
                    end else if (hit1 && wr_data == CD_ERSETUP && !susp) begin
                        nxt = S_ERS3;
                    end
                end
                S_PROG: d_prog = 1'b1;
                S_ERS3: if (wr_data == CD_KEY_A && hit1) nxt = S_ERS4;
                S_ERS4: if (wr_data == CD_KEY_B && hit2) nxt = S_ERS5;
                S_ERS5: begin
                    if (wr_data == CD_BLKCONF) begin
                        nxt = S_ETMR; add_blk = 1'b1;
                        tmr_restart = 1'b1; tmr_cancel = 1'b0;
                    end else if (wr_data == CD_CHIP && hit1) begin
                        d_cerase = 1'b1;
                    end
                end
                S_ETMR: if (wr_data == CD_BLKCONF) begin
                    nxt = S_ETMR; add_blk = 1'b1;
                    tmr_restart = 1'b1; tmr_cancel = 1'b0;
                end
                default: ;
            endcase
        end else if (tmr_exp) begin
            nxt = S_IDLE; d_berase = 1'b1;
        end
    end

    // Sequencer state, mode flags and registered request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            asel  <= 1'b0;
            susp  <= 1'b0;
            {req_read_reset, req_autosel, req_program, req_block_erase,
             req_chip_erase, req_suspend, req_resume} <= '0;
        end else begin
            state <= nxt;
            if (asel_set)      asel <= 1'b1;
            else if (asel_clr || d_rreset) asel <= 1'b0;
            if (d_susp)        susp <= 1'b1;
            else if (d_resume) susp <= 1'b0;
            {req_read_reset, req_autosel, req_program, req_block_erase,
             req_chip_erase, req_suspend, req_resume}
                <= {d_rreset, d_asel, d_prog, d_berase, d_cerase, d_susp, d_resume};
        end
    end

    // Program target capture and block list accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_mask <= '0;
        end else begin
            if (d_prog) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (state == S_IDLE) erase_mask <= '0;
            else if (add_blk)    erase_mask <= erase_mask | blk_sel;
        end
    end

    // Read source selection for the output multiplexer.
    always_comb begin
        if (eng_busy || state == S_ETMR) read_mode = RM_STATUS;
        else if (asel)                   read_mode = RM_SIG;
        else                             read_mode = RM_ARRAY;
    end

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_read_reset, req_autosel, req_program, req_block_erase,
                  req_chip_erase, req_suspend, req_resume})); // R8
    AST_BERASE_HAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        req_block_erase |-> (erase_mask != '0)); // R5
    AST_MASK_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ETMR && $past(state) == S_ETMR)
            |-> ((erase_mask & $past(erase_mask)) == $past(erase_mask))); // R5
    AST_BUSY_BLOCKS_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> !(req_read_reset || req_autosel || req_program ||
                       req_chip_erase || req_resume)); // R8
    AST_SUSP_NEEDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        req_suspend |-> $past(eng_erase_busy)); // R8
    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_program |=> !req_program); // R3
    AST_SUSP_NO_RRESET: assert property (@(posedge clk) disable iff (!rst_n)
        susp |=> !req_read_reset); // R7
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 8;
    localparam int NV         = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        eng_prog_busy = 1'b0;
    logic        eng_erase_busy = 1'b0;
    logic        req_read_reset, req_autosel, req_program, req_block_erase;
    logic        req_chip_erase, req_suspend, req_resume;
    logic [19:0] prog_addr;
    logic [7:0]  prog_data;
    logic [18:0] erase_mask;
    logic [1:0]  read_mode;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(.ADDR_W(20), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_prog_busy(eng_prog_busy), .eng_erase_busy(eng_erase_busy),
        .req_read_reset(req_read_reset), .req_autosel(req_autosel),
        .req_program(req_program), .req_block_erase(req_block_erase),
        .req_chip_erase(req_chip_erase), .req_suspend(req_suspend),
        .req_resume(req_resume), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_mask(erase_mask), .read_mode(read_mode)
    );

    // {word_mode, addr, data, expected requests [rreset asel prog berase cerase susp resume], read_mode}
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, 20'h00000, 8'hF0, 7'b1000000, 2'b00},  // R7 bare F0
        {1'b1, 20'h0F555, 8'hAA, 7'b0000000, 2'b00},  // R1 high bits ignored
        {1'b1, 20'h002AA, 8'h55, 7'b0000000, 2'b00},
        {1'b1, 20'h00555, 8'h90, 7'b0100000, 2'b01},  // R2
        {1'b1, 20'h12345, 8'hF0, 7'b1000000, 2'b00},  // R7
        {1'b0, 20'h00AAA, 8'hAA, 7'b0000000, 2'b00},  // R1 byte mode
        {1'b0, 20'h00555, 8'h55, 7'b0000000, 2'b00},
        {1'b0, 20'h00AAA, 8'hA0, 7'b0000000, 2'b00},
        {1'b0, 20'h2468B, 8'h5A, 7'b0010000, 2'b00},  // R3
        {1'b1, 20'h00555, 8'hAA, 7'b0000000, 2'b00},
        {1'b1, 20'h002AA, 8'h55, 7'b0000000, 2'b00},
        {1'b1, 20'h00555, 8'h80, 7'b0000000, 2'b00},
        {1'b1, 20'h00555, 8'hAA, 7'b0000000, 2'b00},
        {1'b1, 20'h002AA, 8'h55, 7'b0000000, 2'b00},
        {1'b1, 20'h00555, 8'h10, 7'b0000100, 2'b00},  // R4
        {1'b1, 20'h00555, 8'hAA, 7'b0000000, 2'b00},
        {1'b1, 20'h002AB, 8'h55, 7'b0000000, 2'b00},  // R6 bad second unlock
        {1'b1, 20'h00555, 8'h90, 7'b0000000, 2'b00},  // R6 not unlocked
        {1'b0, 20'h00555, 8'hAA, 7'b0000000, 2'b00},  // R1 word address in byte mode
        {1'b0, 20'h00555, 8'h55, 7'b0000000, 2'b00},
        {1'b0, 20'h00AAA, 8'h90, 7'b0000000, 2'b00},
        {1'b1, 20'h00555, 8'hAA, 7'b0000000, 2'b00},
        {1'b1, 20'h002AA, 8'h55, 7'b0000000, 2'b00},
        {1'b1, 20'h00000, 8'hF0, 7'b1000000, 2'b00}   // R7 after unlock
    };

    function automatic logic [6:0] reqs();
        return {req_read_reset, req_autosel, req_program, req_block_erase,
                req_chip_erase, req_suspend, req_resume};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic wm, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        word_mode = wm; wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic erase_prefix();
        do_wr(1'b1, 20'h00555, 8'hAA);
        do_wr(1'b1, 20'h002AA, 8'h55);
        do_wr(1'b1, 20'h00555, 8'h80);
        do_wr(1'b1, 20'h00555, 8'hAA);
        do_wr(1'b1, 20'h002AA, 8'h55);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset requests", 64'(reqs()), 64'h0);
        chk("R10 reset read_mode", 64'(read_mode), 64'h0);
        chk("R10 reset mask", 64'(erase_mask), 64'h0);

        for (int i = 0; i < NV; i++) begin
            do_wr(VEC[i][37], VEC[i][36:17], VEC[i][16:9]);
            chk($sformatf("vec%0d requests", i), 64'(reqs()), 64'(VEC[i][8:2]));
            chk($sformatf("vec%0d read_mode", i), 64'(read_mode), 64'(VEC[i][1:0]));
        end

        // R3 captured target
        do_wr(1'b1, 20'h00555, 8'hAA);
        do_wr(1'b1, 20'h002AA, 8'h55);
        do_wr(1'b1, 20'h00555, 8'hA0);
        do_wr(1'b1, 20'h7ABCD, 8'h3C);
        chk("R3 program pulse", 64'(req_program), 64'h1);
        chk("R3 prog_addr", 64'(prog_addr), 64'h7ABCD);
        chk("R3 prog_data", 64'(prog_data), 64'h3C);

        // R5 multi-block collection with restart
        erase_prefix();
        do_wr(1'b1, 20'h08000, 8'h30);
        chk("R9 status while collecting", 64'(read_mode), 64'h2);
        repeat (3) @(negedge clk);
        do_wr(1'b0, 20'hFA000, 8'h30);
        do_wr(1'b1, 20'h78000, 8'h30);
        for (int k = 1; k < TMO; k++) begin
            @(negedge clk);
            chk("R5 no early erase", 64'(req_block_erase), 64'h0);
        end
        @(negedge clk);
        chk("R5 erase request", 64'(req_block_erase), 64'h1);
        chk("R5 erase mask", 64'(erase_mask), 64'h28002);
        @(negedge clk);
        chk("R5 mask cleared", 64'(erase_mask), 64'h0);

        // R6 abort while collecting
        erase_prefix();
        do_wr(1'b1, 20'h00000, 8'h30);
        do_wr(1'b1, 20'h00000, 8'h55);
        chk("R6 abort read_mode", 64'(read_mode), 64'h0);
        repeat (TMO + 3) @(negedge clk);
        chk("R6 no erase after abort", 64'(req_block_erase), 64'h0);
        chk("R6 mask dropped", 64'(erase_mask), 64'h0);

        // R6 wrong unlock before confirm
        do_wr(1'b1, 20'h00555, 8'hAA);
        do_wr(1'b1, 20'h002AA, 8'h55);
        do_wr(1'b1, 20'h00555, 8'h80);
        do_wr(1'b1, 20'h00555, 8'hAA);
        do_wr(1'b1, 20'h002AA, 8'hAA);
        do_wr(1'b1, 20'h00000, 8'h30);
        chk("R6 confirm after bad unlock", 64'(read_mode), 64'h0);
        repeat (TMO + 3) @(negedge clk);
        chk("R6 no erase after bad unlock", 64'(req_block_erase), 64'h0);

        // R8 / R7 suspend and resume
        eng_erase_busy = 1'b1;
        @(negedge clk);
        chk("R9 status while erasing", 64'(read_mode), 64'h2);
        do_wr(1'b1, 20'h00000, 8'hF0);
        chk("R7 F0 ignored while erasing", 64'(reqs()), 64'h0);
        do_wr(1'b1, 20'h00555, 8'hAA);
        do_wr(1'b1, 20'h00000, 8'hB0);
        chk("R8 suspend", 64'(reqs()), 64'b0000010);
        eng_erase_busy = 1'b0;
        do_wr(1'b1, 20'h00000, 8'hF0);
        chk("R7 F0 ignored while suspended", 64'(reqs()), 64'h0);
        do_wr(1'b1, 20'h33333, 8'h30);
        chk("R8 resume", 64'(reqs()), 64'b0000001);
        do_wr(1'b1, 20'h00000, 8'hF0);
        chk("R7 F0 after resume", 64'(reqs()), 64'b1000000);

        // R8 suspend refused during program
        eng_prog_busy = 1'b1;
        do_wr(1'b1, 20'h00000, 8'hB0);
        chk("R8 no suspend while programming", 64'(reqs()), 64'h0);
        chk("R9 status while programming", 64'(read_mode), 64'h2);
        eng_prog_busy = 1'b0;

        // R10 reset in mid sequence
        do_wr(1'b1, 20'h00555, 8'hAA);
        do_wr(1'b1, 20'h002AA, 8'h55);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_wr(1'b1, 20'h00555, 8'h90);
        chk("R10 sequence cleared", 64'(reqs()), 64'h0);
        chk("R10 array after reset", 64'(read_mode), 64'h0);

        finish_run();
    end
endmodule